// File: doc/BRIEF.md
# USB Device Clock Gating Controller

This block decides, cycle by cycle, which clocks of a USB device controller may run. It runs from an always-on reference clock. It watches the bus for activity. After a long enough idle stretch it declares suspend and drops the enable of the 48 MHz device clock. Software can keep that clock alive during suspend by setting a request bit. A status bit, delayed through a synchronizer, tells software when the clock is actually up.

DMA accesses turn on the bus-master clock enable automatically. The enable is held for a retriggerable hold-off window after the last access. A second control bit forces the master clock on regardless of traffic. The register-slave clock follows the peripheral power enable. Dropping the power enable gates every clock and wipes the software requests. A need-clock flag, the OR of the status bits, goes to the chip power manager so the chip can leave power-down.

The suspend and hold-off intervals are parameters counted in reference-clock cycles. The defaults correspond to 3 ms and 2 ms at 48 MHz.

Top module: `usb_clkgate_ctrl`

## Requirements
- R1: `slave_clk_en` is high exactly when `pwr_en` is high, in the same cycle.
- R2: After `SUSPEND_CYCLES` consecutive clock edges with `pwr_en` high and `bus_active` low, `suspended` goes high. From then on `dev_clk_en` is low unless the device-clock request bit (control register bit 0) is set. One edge earlier, `suspended` is still low and `dev_clk_en` is still high.
- R3: A clock edge that samples `bus_active` high clears the idle count. After that edge `suspended` is low and `dev_clk_en` is high.
- R4: While control bit 0 is set and `pwr_en` is high, `dev_clk_en` stays high even in suspend. Clearing the bit lets `dev_clk_en` fall in suspend.
- R5: An edge that samples `dma_access` high with `pwr_en` high loads the hold-off timer. `mst_clk_en` is then high for exactly `DMA_HOLD_CYCLES` cycles after the last such edge and falls on its own. A new access restarts the full window.
- R6: While control bit 1 (master-clock force) is set and `pwr_en` is high, `mst_clk_en` stays high with no DMA traffic.
- R7: Status register bit 0 mirrors `dev_clk_en` and bit 1 mirrors `mst_clk_en`. Each bit changes two clock edges after its enable changes.
- R8: `need_clk` is high exactly when any status bit is set.
- R9: With `pwr_en` low, `dev_clk_en`, `mst_clk_en` and `slave_clk_en` are low in the same cycle. On the next edge the control bits, idle count and hold-off timer are cleared. Register writes are ignored while `pwr_en` is low.
- R10: The register port answers every request in the cycle it is made (`reg_ready` = `reg_valid`, read data combinational). The control register is at offset 0x0 and reads back only bits 1:0. The status register is at offset 0x4 and ignores writes. Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Peripheral power enable |
| bus_active | input | 1 | USB bus activity seen this cycle |
| dma_access | input | 1 | One-cycle strobe per DMA access |
| reg_valid | input | 1 | Register request valid |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Request accepted this cycle |
| reg_rdata | output | 32 | Read data |
| slave_clk_en | output | 1 | Register-slave clock enable |
| dev_clk_en | output | 1 | 48 MHz device clock enable |
| mst_clk_en | output | 1 | Bus-master (DMA) clock enable |
| suspended | output | 1 | Bus idle long enough to count as suspend |
| need_clk | output | 1 | Wake request to the chip power manager |

## Verification
The bench probes the suspend threshold one edge before and at the limit. A timer off by one would drop the device clock a cycle early or late. It pulses bus activity during suspend and checks that the device clock returns after a single edge, which catches a design that only decrements the idle count.

A table drives DMA strobes in isolated, back-to-back and retriggered patterns. A hold-off window that does not restart, or that ends one cycle late, shows up as a wrong master enable at a specific step. Directed cases cover the two-edge status lag, writes to the status register, and power-off wiping the requests; a design that lets software state survive power-off would read back nonzero control bits.

// File: rtl/usb_cg_pkg.sv
package usb_cg_pkg;

    localparam int REG_ADDR_W = 4;
    localparam int REG_DATA_W = 32;

    localparam logic [REG_ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [REG_ADDR_W-1:0] OFS_STAT = 4'h4;

    localparam int CTRL_DEV_BIT = 0;
    localparam int CTRL_MST_BIT = 1;
    localparam int CTRL_BITS    = 2;

    typedef struct packed {
        logic mst_force;
        logic dev_req;
    } ctrl_t;

endpackage

// File: rtl/usb_cg_idle_timer.sv
module usb_cg_idle_timer #(
    parameter int LIMIT = 144000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic suspended
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } idle_st_t;

    idle_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIM) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign suspended = (st_q.cnt == LIM);

    p_suspend_after_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> !$past(clear));

    p_wake_on_activity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !suspended);

endmodule

// File: rtl/usb_cg_hold_timer.sv
module usb_cg_hold_timer #(
    parameter int HOLD = 96000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic strobe,
    output logic active
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] RELOAD = CW'(HOLD);

    typedef struct packed {
        logic [CW-1:0] left;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.left = '0;
        end else if (strobe) begin
            st_d.left = RELOAD;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.left != '0);

    p_strobe_starts_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !clear) |=> active);

    p_hold_ends_quietly_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> !$past(strobe));

endmodule

// File: rtl/usb_cg_sync.sv
module usb_cg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d[g];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/usb_cg_regs.sv
module usb_cg_regs
    import usb_cg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_en,
    input  logic                  reg_valid,
    input  logic                  reg_write,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    input  logic [CTRL_BITS-1:0]  status,
    output logic                  reg_ready,
    output logic [REG_DATA_W-1:0] reg_rdata,
    output ctrl_t                 ctrl
);
    localparam int PAD_W = REG_DATA_W - CTRL_BITS;

    ctrl_t ctrl_d, ctrl_q;
    logic  wr_ctrl;
    logic  unused_wdata;

    assign unused_wdata = ^reg_wdata[REG_DATA_W-1:CTRL_BITS];
    assign wr_ctrl      = reg_valid && reg_write && (reg_addr == OFS_CTRL);

    always_comb begin
        ctrl_d = ctrl_q;
        if (!pwr_en) begin
            ctrl_d = '0;
        end else if (wr_ctrl) begin
            ctrl_d.dev_req   = reg_wdata[CTRL_DEV_BIT];
            ctrl_d.mst_force = reg_wdata[CTRL_MST_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_valid && !reg_write) begin
            unique case (reg_addr)
                OFS_CTRL: reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
                OFS_STAT: reg_rdata = {{PAD_W{1'b0}}, status};
                default:  reg_rdata = '0;
            endcase
        end
    end

    assign reg_ready = reg_valid;
    assign ctrl      = ctrl_q;

    p_stat_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && (reg_addr == OFS_STAT) && pwr_en) |=> $stable(ctrl_q));

    p_power_off_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> (ctrl_q == '0));

endmodule

// File: rtl/usb_clkgate_ctrl.sv
module usb_clkgate_ctrl
    import usb_cg_pkg::*;
#(
    parameter int SUSPEND_CYCLES  = 144000,
    parameter int DMA_HOLD_CYCLES = 96000,
    parameter int SYNC_STAGES     = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_en,
    input  logic        bus_active,
    input  logic        dma_access,
    input  logic        reg_valid,
    input  logic        reg_write,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic        reg_ready,
    output logic [31:0] reg_rdata,
    output logic        slave_clk_en,
    output logic        dev_clk_en,
    output logic        mst_clk_en,
    output logic        suspended,
    output logic        need_clk
);
    ctrl_t                ctrl;
    logic                 idle_clear;
    logic                 hold_clear;
    logic                 hold_strobe;
    logic                 hold_active;
    logic [CTRL_BITS-1:0] enables;
    logic [CTRL_BITS-1:0] status;

    assign idle_clear  = bus_active || !pwr_en;
    assign hold_clear  = !pwr_en;
    assign hold_strobe = dma_access && pwr_en;

    usb_cg_idle_timer #(.LIMIT(SUSPEND_CYCLES)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (idle_clear),
        .suspended (suspended)
    );

    usb_cg_hold_timer #(.HOLD(DMA_HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (hold_clear),
        .strobe (hold_strobe),
        .active (hold_active)
    );

    usb_cg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_en    (pwr_en),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status    (status),
        .reg_ready (reg_ready),
        .reg_rdata (reg_rdata),
        .ctrl      (ctrl)
    );

    always_comb begin
        slave_clk_en = pwr_en;
        dev_clk_en   = pwr_en && (!suspended || ctrl.dev_req);
        mst_clk_en   = pwr_en && (hold_active || ctrl.mst_force);
        enables      = '0;
        enables[CTRL_DEV_BIT] = dev_clk_en;
        enables[CTRL_MST_BIT] = mst_clk_en;
    end

    usb_cg_sync #(.WIDTH(CTRL_BITS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (enables),
        .dout  (status)
    );

    assign need_clk = |status;

    p_power_off_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (!dev_clk_en && !mst_clk_en));

    p_req_holds_dev_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.dev_req && pwr_en) |-> dev_clk_en);

    p_force_holds_mst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mst_force && pwr_en) |-> mst_clk_en);

    p_suspend_gates_dev_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && !ctrl.dev_req) |-> !dev_clk_en);

endmodule

// File: tb/usb_clkgate_ctrl_tb.sv
module usb_clkgate_ctrl_tb;

    localparam int SUSP = 12;
    localparam int HOLD = 4;

    // bit1 = dma_access driven, bit0 = expected mst_clk_en after the edge
    localparam logic [1:0] DMA_VEC [0:15] = '{
        2'b11, 2'b01, 2'b01, 2'b01, 2'b00, 2'b00, 2'b11, 2'b01,
        2'b11, 2'b01, 2'b01, 2'b01, 2'b00, 2'b11, 2'b11, 2'b01
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pwr_en;
    logic        bus_active;
    logic        dma_access;
    logic        reg_valid;
    logic        reg_write;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_ready;
    logic [31:0] reg_rdata;
    logic        slave_clk_en;
    logic        dev_clk_en;
    logic        mst_clk_en;
    logic        suspended;
    logic        need_clk;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] rv;
    logic        rdy;

    always #4 clk = ~clk;

    usb_clkgate_ctrl #(
        .SUSPEND_CYCLES  (SUSP),
        .DMA_HOLD_CYCLES (HOLD),
        .SYNC_STAGES     (2)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_en       (pwr_en),
        .bus_active   (bus_active),
        .dma_access   (dma_access),
        .reg_valid    (reg_valid),
        .reg_write    (reg_write),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_ready    (reg_ready),
        .reg_rdata    (reg_rdata),
        .slave_clk_en (slave_clk_en),
        .dev_clk_en   (dev_clk_en),
        .mst_clk_en   (mst_clk_en),
        .suspended    (suspended),
        .need_clk     (need_clk)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_valid = 1'b0; reg_write = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1;
        d   = reg_rdata;
        rdy = reg_ready;
        reg_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pwr_en = 1'b0; bus_active = 1'b0; dma_access = 1'b0;
        reg_valid = 1'b0; reg_write = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick(); #1;

        // reset state, power off
        check("R9 reset dev_clk_en", dev_clk_en, 0);
        check("R9 reset mst_clk_en", mst_clk_en, 0);
        check("R1 reset slave_clk_en", slave_clk_en, 0);
        check("R8 reset need_clk", need_clk, 0);
        rd(4'h4, rv); check("R7 reset status", rv, 0);

        // writes ignored while power is off
        wr(4'h0, 32'h3);
        rd(4'h0, rv); check("R9 write while off", rv, 0);
        check("R9 dev off after write", dev_clk_en, 0);

        // power up, clear idle count
        pwr_en = 1'b1; bus_active = 1'b1; #1;
        check("R1 slave follows pwr_en", slave_clk_en, 1);
        tick();
        bus_active = 1'b0;
        repeat (SUSP - 1) tick();
        #1;
        check("R2 one edge before limit dev", dev_clk_en, 1);
        check("R2 one edge before limit susp", suspended, 0);
        tick(); #1;
        check("R2 at limit dev", dev_clk_en, 0);
        check("R2 at limit susp", suspended, 1);
        repeat (3) tick();
        rd(4'h4, rv); check("R7 status dev off", rv, 0);

        // resume
        bus_active = 1'b1;
        tick();
        bus_active = 1'b0; #1;
        check("R3 resume dev", dev_clk_en, 1);
        check("R3 resume susp", suspended, 0);
        rd(4'h4, rv); check("R7 lag edge0", rv, 0);
        tick(); rd(4'h4, rv); check("R7 lag edge1", rv, 0);
        tick(); rd(4'h4, rv); check("R7 lag edge2", rv, 1);
        check("R8 need_clk with dev on", need_clk, 1);

        // back into suspend
        repeat (SUSP - 2) tick();
        #1;
        check("R2 resuspend susp", suspended, 1);
        check("R2 resuspend dev", dev_clk_en, 0);
        tick(); tick(); #1;
        check("R8 need_clk low", need_clk, 0);

        // software request during suspend
        wr(4'h0, 32'h1);
        check("R4 request raises dev", dev_clk_en, 1);
        tick(); tick();
        rd(4'h4, rv); check("R7 status after request", rv, 1);
        repeat (20) tick();
        #1;
        check("R4 held through suspend", dev_clk_en, 1);
        check("R4 still suspended", suspended, 1);

        // readback mask and master force
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, rv); check("R10 ctrl readback mask", rv, 3);
        check("R10 ready with valid", rdy, 1);
        check("R6 force raises mst", mst_clk_en, 1);
        repeat (30) tick();
        #1;
        check("R6 force holds mst", mst_clk_en, 1);
        rd(4'h4, rv); check("R7 both status bits", rv, 3);

        // status write ignored, unmapped offset
        wr(4'h4, 32'h0);
        rd(4'h0, rv); check("R10 status write ignored ctrl", rv, 3);
        check("R10 status write ignored dev", dev_clk_en, 1);
        rd(4'h8, rv); check("R10 unmapped reads zero", rv, 0);

        wr(4'h0, 32'h0);
        check("R4 release dev", dev_clk_en, 0);
        check("R6 release mst", mst_clk_en, 0);

        // DMA hold-off table
        for (int i = 0; i < 16; i++) begin
            dma_access = DMA_VEC[i][1];
            tick(); #1;
            check($sformatf("R5 dma step %0d", i), mst_clk_en, DMA_VEC[i][0]);
        end
        dma_access = 1'b0;

        // power off wipes requests
        wr(4'h0, 32'h3);
        pwr_en = 1'b0; #1;
        check("R9 off dev", dev_clk_en, 0);
        check("R9 off mst", mst_clk_en, 0);
        check("R1 off slave", slave_clk_en, 0);
        tick();
        pwr_en = 1'b1;
        rd(4'h0, rv); check("R9 ctrl cleared", rv, 0);
        check("R9 mst stays off", mst_clk_en, 0);
        check("R9 idle count reset", dev_clk_en, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule